// File: doc/BRIEF.md
# Calibrated Seconds Real-Time Counter

This block keeps a running count of whole seconds, derived from a slow crystal tick that arrives as a one-cycle `tickEn` strobe. The calibration word sets how many ticks make up one second. Its low 16 bits hold the tick count minus one. Bits 19:16 hold a fractional trim that adds one extra tick every sixteen seconds per unit. Bit 20 starts or stops counting. Writing the calibration word also restarts the tick prescaler, so the next second lands exactly one full period after the write.

Software sets the time through a set-time register. The written value is not copied into the counter straight away. It waits until the next second boundary and then replaces the normal increment for that boundary. Until then, software can read the pending value back from a separate offset. A sticky seconds flag records each boundary and is cleared by writing one to it. A control register holds a stored battery-switch enable bit, which is driven out of the block, and an interrupt enable bit that gates the flag onto `secIrq`. The register port is a plain single-cycle interface: reads are combinational from `regAddr`, and writes take effect at the clock edge where `regWrEn` is high.

Top module: `secClock`

## Requirements
- R1: After reset, offset 0x08 reads 0x198233, and offsets 0x04, 0x10, 0x20 and 0x40 all read 0. `secIrq` and `battEn` are low.
- R2: Calibration bits [15:0] hold N, the number of ticks per second minus one. With bit 20 set, a second boundary occurs on the (N+1)-th `tickEn` after the previous boundary. A write to offset 0x08 stores the low 21 bits of the data, which read back at 0x08. The write clears the prescaler, so the next boundary comes exactly N+1 ticks after the write.
- R3: Calibration bits [19:16] hold F. A 4-bit accumulator starts at 0 and is cleared by every calibration write. At each boundary, F is added to the accumulator. If that addition carries out of 4 bits, the following second lasts N+2 ticks instead of N+1.
- R4: While `tickEn` is low, or while calibration bit 20 is 0, the time does not advance.
- R5: If no load is pending, the current time at offset 0x10 increases by exactly 1 at each boundary.
- R6: A write to offset 0x00 does not change the current time immediately. At the next boundary, the written value replaces the increment. Offset 0x04 returns the last value written to 0x00. Offset 0x00 itself reads 0.
- R7: Status bit 0 at offset 0x20 is set at each boundary. Writing 1 to bit 0 clears it. Writing 0 has no effect. If a set and a clear happen in the same cycle, the set wins.
- R8: At offset 0x40, bit 31 is the battery enable and bit 0 is the interrupt enable. Both are read/write. All other bits read 0. The `battEn` output follows bit 31.
- R9: `secIrq` is high exactly when status bit 0 and control bit 0 are both 1.
- R10: Reads of unmapped offsets return 0. Writes to offsets 0x04 and 0x10 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | One-cycle pulse per crystal tick |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Byte offset of the register access |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| secIrq | output | 1 | Seconds interrupt request |
| battEn | output | 1 | Stored battery-switch enable |

## Verification
Every register write, and every tick that completes a second, shows up in the read data and in `secIrq` after the very next rising edge. The bench therefore drives each stimulus at a falling edge and removes it at the following falling edge. It reads a settled value one nanosecond after that edge. For each second, the bench checks that the time has not moved after one tick fewer than the expected period, and that it has moved after the last tick. The expected period comes from N and from the running sum of F, calculated arithmetically in the bench.

// File: rtl/secclk_pkg.sv
package secclk_pkg;

  typedef struct packed {
    logic setTime;
    logic calib;
    logic statClr;
    logic ctrl;
  } strobe_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_SETBACK,
    RD_CALIB,
    RD_CUR,
    RD_STATUS,
    RD_CTRL
  } rdsel_t;

  localparam logic [7:0] OFS_SET_WR  = 8'h00;
  localparam logic [7:0] OFS_SET_RD  = 8'h04;
  localparam logic [7:0] OFS_CALIB   = 8'h08;
  localparam logic [7:0] OFS_CUR     = 8'h10;
  localparam logic [7:0] OFS_STATUS  = 8'h20;
  localparam logic [7:0] OFS_CTRL    = 8'h40;

endpackage

// File: rtl/secclk_ctrl.sv
module secclk_ctrl
  import secclk_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           strb,
  output rdsel_t            rdSel
);

  localparam logic [ADDR_W-1:0] A_SET_WR = ADDR_W'(OFS_SET_WR);
  localparam logic [ADDR_W-1:0] A_SET_RD = ADDR_W'(OFS_SET_RD);
  localparam logic [ADDR_W-1:0] A_CALIB  = ADDR_W'(OFS_CALIB);
  localparam logic [ADDR_W-1:0] A_CUR    = ADDR_W'(OFS_CUR);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);

  // Only writable offsets raise a strobe; read-only ones are dropped here.
  always_comb begin
    strb         = '0;
    strb.setTime = regWrEn && (regAddr == A_SET_WR);
    strb.calib   = regWrEn && (regAddr == A_CALIB);
    strb.statClr = regWrEn && (regAddr == A_STATUS);
    strb.ctrl    = regWrEn && (regAddr == A_CTRL);
  end

  always_comb begin
    unique case (regAddr)
      A_SET_RD: rdSel = RD_SETBACK;
      A_CALIB:  rdSel = RD_CALIB;
      A_CUR:    rdSel = RD_CUR;
      A_STATUS: rdSel = RD_STATUS;
      A_CTRL:   rdSel = RD_CTRL;
      default:  rdSel = RD_NONE;
    endcase
  end

endmodule

// File: rtl/secclk_dp.sv
module secclk_dp
  import secclk_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter int          PRESC_W = 16,
  parameter int          FRAC_W  = 4,
  parameter logic [PRESC_W+FRAC_W:0] CAL_RST = 21'h198233
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tickEn,
  input  strobe_t               strb,
  input  rdsel_t                rdSel,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  output logic [DATA_W-1:0]     curTime,
  output logic [DATA_W-1:0]     setReg,
  output logic                  pending,
  output logic                  secEvt,
  output logic [PRESC_W:0]      tickCnt,
  output logic                  statusBit,
  output logic                  irqEn,
  output logic                  battEn
);

  localparam int CAL_W    = PRESC_W + FRAC_W + 1;
  localparam int EN_BIT   = PRESC_W + FRAC_W;
  localparam int BATT_BIT = DATA_W - 1;

  logic [CAL_W-1:0]  calReg;
  logic [FRAC_W-1:0] fracAcc;
  logic              extraTick;
  logic              countOn;
  logic [PRESC_W:0]  limit;
  logic [FRAC_W:0]   fracSum;

  assign countOn = tickEn && calReg[EN_BIT] && !strb.calib;
  assign limit   = {1'b0, calReg[PRESC_W-1:0]} + (PRESC_W+1)'(extraTick);
  assign secEvt  = countOn && (tickCnt == limit);
  assign fracSum = {1'b0, fracAcc} + {1'b0, calReg[PRESC_W +: FRAC_W]};

  // prescaler and fractional trim
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      calReg    <= CAL_RST;
      tickCnt   <= '0;
      fracAcc   <= '0;
      extraTick <= 1'b0;
    end else if (strb.calib) begin
      calReg    <= regWrData[CAL_W-1:0];
      tickCnt   <= '0;
      fracAcc   <= '0;
      extraTick <= 1'b0;
    end else if (countOn) begin
      if (secEvt) begin
        tickCnt   <= '0;
        fracAcc   <= fracSum[FRAC_W-1:0];
        extraTick <= fracSum[FRAC_W];
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  // seconds counter with deferred load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curTime <= '0;
      setReg  <= '0;
      pending <= 1'b0;
    end else begin
      if (secEvt) begin
        curTime <= pending ? setReg : curTime + 1'b1;
      end
      if (strb.setTime) begin
        setReg  <= regWrData;
        pending <= 1'b1;
      end else if (secEvt) begin
        pending <= 1'b0;
      end
    end
  end

  // status and control
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusBit <= 1'b0;
      irqEn     <= 1'b0;
      battEn    <= 1'b0;
    end else begin
      if (secEvt) begin
        statusBit <= 1'b1;
      end else if (strb.statClr && regWrData[0]) begin
        statusBit <= 1'b0;
      end
      if (strb.ctrl) begin
        irqEn  <= regWrData[0];
        battEn <= regWrData[BATT_BIT];
      end
    end
  end

  always_comb begin
    regRdData = '0;
    unique case (rdSel)
      RD_SETBACK: regRdData = setReg;
      RD_CALIB:   regRdData = DATA_W'(calReg);
      RD_CUR:     regRdData = curTime;
      RD_STATUS:  regRdData[0] = statusBit;
      RD_CTRL: begin
        regRdData[0]        = irqEn;
        regRdData[BATT_BIT] = battEn;
      end
      default:    regRdData = '0;
    endcase
  end

endmodule

// File: rtl/secClock.sv
module secClock
  import secclk_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int PRESC_W = 16,
  parameter int FRAC_W  = 4,
  parameter logic [PRESC_W+FRAC_W:0] CAL_RST = 21'h198233
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              secIrq,
  output logic              battEn
);

  strobe_t           strb;
  rdsel_t            rdSel;
  logic [DATA_W-1:0] curTime;
  logic [DATA_W-1:0] setReg;
  logic              pending;
  logic              secEvt;
  logic [PRESC_W:0]  tickCnt;
  logic              statusBit;
  logic              irqEn;
  logic              wrCalib;

  assign wrCalib = strb.calib;

  secclk_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strb    (strb),
    .rdSel   (rdSel)
  );

  secclk_dp #(
    .DATA_W  (DATA_W),
    .PRESC_W (PRESC_W),
    .FRAC_W  (FRAC_W),
    .CAL_RST (CAL_RST)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .strb      (strb),
    .rdSel     (rdSel),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .curTime   (curTime),
    .setReg    (setReg),
    .pending   (pending),
    .secEvt    (secEvt),
    .tickCnt   (tickCnt),
    .statusBit (statusBit),
    .irqEn     (irqEn),
    .battEn    (battEn)
  );

  assign secIrq = statusBit && irqEn;

endmodule

// File: rtl/secClock_chk.sv
module secClock_chk #(
  parameter int DATA_W  = 32,
  parameter int PRESC_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              secEvt,
  input logic              pending,
  input logic [DATA_W-1:0] curTime,
  input logic [DATA_W-1:0] setReg,
  input logic              wrCalib,
  input logic [PRESC_W:0]  tickCnt,
  input logic              statusBit,
  input logic              irqEn,
  input logic              secIrq
);

  // R2
  calib_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrCalib |=> (tickCnt == '0));

  // R5
  plain_increment_chk: assert property (@(posedge clk) disable iff (!rstN)
    (secEvt && !pending) |=> (curTime == $past(curTime) + 1'b1));

  // R6
  deferred_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (secEvt && pending) |=> (curTime == $past(setReg)));

  // R4
  hold_between_chk: assert property (@(posedge clk) disable iff (!rstN)
    !secEvt |=> $stable(curTime));

  // R7
  status_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    secEvt |=> statusBit);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    secIrq |-> (statusBit && irqEn));

endmodule

bind secClock secClock_chk #(.DATA_W(DATA_W), .PRESC_W(PRESC_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .secEvt    (secEvt),
  .pending   (pending),
  .curTime   (curTime),
  .setReg    (setReg),
  .wrCalib   (wrCalib),
  .tickCnt   (tickCnt),
  .statusBit (statusBit),
  .irqEn     (irqEn),
  .secIrq    (secIrq)
);

// File: tb/test_secClock.sv
`timescale 1ns/1ps
module test_secClock;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        secIrq;
  logic        battEn;

  int nVec = 0;
  int nBad = 0;
  logic [31:0] rv;
  logic [31:0] t0;

  always #5 clk = ~clk;

  secClock i_secClock (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .secIrq(secIrq), .battEn(battEn)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tickEn = 1'b1;
      @(negedge clk);
      tickEn = 1'b0;
    end
  endtask

  initial begin
    #2000000;
    nBad++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(8'h08, rv); check("R1 calib", rv, 32'h198233);
    rd(8'h04, rv); check("R1 setback", rv, 0);
    rd(8'h10, rv); check("R1 cur", rv, 0);
    rd(8'h20, rv); check("R1 status", rv, 0);
    rd(8'h40, rv); check("R1 ctrl", rv, 0);
    check("R1 irq", {31'd0, secIrq}, 0);
    check("R1 batt", {31'd0, battEn}, 0);

    // R2 period of N+1 = 5 ticks, readback masked to 21 bits
    wr(8'h08, 32'hFFE0_0004 | 32'h0010_0000);
    rd(8'h08, rv); check("R2 calib readback", rv, 32'h0010_0004);
    ticks(4);
    rd(8'h10, rv); check("R2 before boundary", rv, 0);
    rd(8'h20, rv); check("R7 status before", rv, 0);
    ticks(1);
    rd(8'h10, rv); check("R2 at boundary", rv, 1);
    rd(8'h20, rv); check("R7 status set", rv, 1);

    // R7 write 0 no effect, write 1 clears
    wr(8'h20, 0);
    rd(8'h20, rv); check("R7 write zero", rv, 1);
    wr(8'h20, 1);
    rd(8'h20, rv); check("R7 w1c", rv, 0);

    // R2 calibration write restarts prescaler mid-second
    ticks(3);
    wr(8'h08, 32'h0010_0004);
    ticks(4);
    rd(8'h10, rv); check("R2 restart hold", rv, 1);
    ticks(1);
    rd(8'h10, rv); check("R2 restart boundary", rv, 2);

    // R5 several increments
    for (int s = 0; s < 4; s++) begin
      ticks(5);
      rd(8'h10, rv); check("R5 increment", rv, 32'd3 + 32'(s));
    end

    // R6 deferred load
    wr(8'h08, 32'h0010_0004);
    wr(8'h00, 32'd1000);
    rd(8'h04, rv); check("R6 setback", rv, 1000);
    rd(8'h00, rv); check("R6 write-only reads 0", rv, 0);
    rd(8'h10, rv); check("R6 not immediate", rv, 6);
    ticks(4);
    rd(8'h10, rv); check("R6 hold", rv, 6);
    ticks(1);
    rd(8'h10, rv); check("R6 loaded", rv, 1000);
    ticks(5);
    rd(8'h10, rv); check("R5 after load", rv, 1001);

    // R10 ignored writes and unmapped reads
    wr(8'h10, 32'd555);
    rd(8'h10, rv); check("R10 cur ro", rv, 1001);
    wr(8'h04, 32'd777);
    rd(8'h04, rv); check("R10 setback ro", rv, 1000);
    rd(8'h0C, rv); check("R10 unmapped 0C", rv, 0);
    rd(8'h30, rv); check("R10 unmapped 30", rv, 0);

    // R4 no ticks, and enable bit cleared
    t0 = 1001;
    repeat (40) @(negedge clk);
    rd(8'h10, rv); check("R4 no tick", rv, t0);
    wr(8'h08, 32'h0000_0004);
    ticks(12);
    rd(8'h10, rv); check("R4 disabled", rv, t0);

    // R8 control, R9 irq
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, rv); check("R8 ctrl mask", rv, 32'h8000_0001);
    check("R8 batt out", {31'd0, battEn}, 1);
    wr(8'h20, 1);
    check("R9 irq no status", {31'd0, secIrq}, 0);
    wr(8'h08, 32'h0010_0001);
    ticks(2);
    check("R9 irq asserted", {31'd0, secIrq}, 1);
    wr(8'h40, 32'h8000_0000);
    check("R9 irq masked", {31'd0, secIrq}, 0);
    check("R8 batt kept", {31'd0, battEn}, 1);
    wr(8'h40, 32'h0000_0001);
    check("R9 irq re-enabled", {31'd0, secIrq}, 1);
    check("R8 batt off", {31'd0, battEn}, 0);
    wr(8'h20, 1);
    check("R9 irq cleared", {31'd0, secIrq}, 0);

    // R3 fraction sweep, N=2
    for (int f = 0; f < 16; f++) begin
      wr(8'h08, 32'h0010_0002 | (32'(f) << 16));
      rd(8'h10, t0);
      for (int k = 1; k <= 18; k++) begin
        int per;
        per = 3;
        if (k >= 2) per = per + ((k - 1) * f) / 16 - ((k - 2) * f) / 16;
        ticks(per - 1);
        rd(8'h10, rv); check("R3 hold", rv, t0 + 32'(k - 1));
        ticks(1);
        rd(8'h10, rv); check("R3 boundary", rv, t0 + 32'(k));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule